// File: doc/BRIEF.md
# SDRAM Bank Auto-Precharge Timing Tracker

This block sits beside an SDRAM command scheduler and follows, separately for each bank, what a read or write with auto-precharge does to that bank's availability. It observes every command issued together with its bank address, the programmed CAS latency and three programmable cycle counts. These are the minimum row-active time (tRAS), the recovery after a read with auto-precharge, and the write-to-activate recovery. From them it works out the cycle in which the bank's internal precharge begins and the cycle in which the bank is idle again.

For every bank the tracker presents three flags. Ready means the bank may take a command now. Idle means only an activate is legal. The precharge flag marks the internal precharge or recovery phase. A one-cycle violation flag reports any command that the bank's current phase does not allow. Such a command has no effect on any bank's timing. The scheduler uses the flags to gate its own issue logic; the data path is not part of the block.

Top module: `ap_bank_tracker`

## Requirements
- R1: A synchronous active-high reset makes every bank idle and ready with the precharge flag low, and clears the violation flag on the following cycle.
- R2: Command code 1 (activate) to an idle bank makes that bank leave idle from the next cycle while it stays ready, and it stays open until a command with auto-precharge arrives.
- R3: Command code 2 (read with auto-precharge) to an open bank drops its ready flag from the next cycle. The internal precharge flag rises at the point CL-1 cycles before the final read beat, where the final beat is CL+3 cycles after the command; the programmed CAS latency is 2 or 3.
- R4: Command code 3 (write with auto-precharge) to an open bank drops its ready flag from the next cycle. The precharge flag rises with the final write beat, 3 cycles after the command, since write data begins in the command cycle.
- R5: The precharge flag never rises earlier than tRAS cycles after the bank's activate; when the latency-derived point is earlier, the flag rises exactly tRAS cycles after the activate.
- R6: After a read with auto-precharge, the bank becomes idle the read-recovery count of cycles after its precharge flag rose; a count of 0 makes it idle in that same cycle.
- R7: After a write with auto-precharge, the bank becomes idle the write-recovery count of cycles after its precharge flag rose.
- R8: The violation flag is high in the cycle after a command that the target bank does not allow, and low otherwise. An activate is allowed only on an idle bank. Codes 2, 3 and any other non-zero code (4 to 7, plain accesses) are allowed only on an open bank. The offending command changes no state.
- R9: A command to one bank has no effect on the flags or timing of any other bank.
- R10: tRAS is sampled with the activate, and the recovery counts with the auto-precharge command; later changes on those inputs do not move a timing already started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Command code: 0 none, 1 activate, 2 read+AP, 3 write+AP, 4-7 other access |
| bank_i | input | BANK_W | Bank addressed by the command |
| cas_lat_i | input | 2 | CAS latency, 2 or 3 |
| tras_i | input | CNT_W | Minimum activate-to-precharge cycles |
| rd_rec_i | input | CNT_W | Recovery cycles after a read with auto-precharge |
| wr_rec_i | input | CNT_W | Recovery cycles after a write with auto-precharge |
| bank_ready_o | output | NUM_BANKS | Bank may accept a command (idle or open) |
| bank_idle_o | output | NUM_BANKS | Bank is precharged; only an activate is legal |
| bank_pchg_o | output | NUM_BANKS | Internal precharge / recovery in progress |
| viol_o | output | 1 | Previous cycle carried an illegal command |

## Verification
A bank whose state register is wrong shows it on the next cycle through its three flags. If it is stuck open after an auto-precharge command, ready stays high where it must fall. If it wrongly reports idle, an activate is accepted where the violation flag should have risen. A wrong countdown or a mis-sampled timing value moves the rising or falling edge of the precharge flag by a whole number of cycles. Comparing every flag of every bank on every cycle against a timestamp model therefore catches an off-by-one within one cycle of the edge it shifts.

// File: rtl/ap_trk_pkg.sv
package ap_trk_pkg;

    typedef enum logic [1:0] {
        BK_IDLE  = 2'd0,
        BK_OPEN  = 2'd1,
        BK_WAIT  = 2'd2,
        BK_RECOV = 2'd3
    } bank_st_e;

    // One bank's view of the command in the current cycle
    typedef struct packed {
        logic act;
        logic rda;
        logic wra;
        logic acc;
    } bank_req_t;

    localparam logic [2:0] CMD_NOP = 3'd0;
    localparam logic [2:0] CMD_ACT = 3'd1;
    localparam logic [2:0] CMD_RDA = 3'd2;
    localparam logic [2:0] CMD_WRA = 3'd3;

    // Cycles from the auto-precharge command to the start of precharge,
    // ignoring the row-active limit.
    function automatic int unsigned pchg_offset(logic is_wr, logic [1:0] cl,
                                                int unsigned burst);
        int unsigned c;
        int unsigned last_beat;
        int unsigned lead;
        c = (cl == 2'd0) ? 1 : int'(cl);
        if (is_wr) begin
            return burst - 1;
        end
        last_beat = c + burst - 1;
        lead      = c - 1;
        return last_beat - lead;
    endfunction

    function automatic bank_req_t decode_cmd(logic [2:0] code);
        bank_req_t r;
        r = '0;
        case (code)
            CMD_NOP: r = '0;
            CMD_ACT: r.act = 1'b1;
            CMD_RDA: r.rda = 1'b1;
            CMD_WRA: r.wra = 1'b1;
            default: r.acc = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ap_trk_cmd_dec.sv
module ap_trk_cmd_dec
    import ap_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [2:0]        cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    output bank_req_t         req_o [NUM_BANKS]
);

    bank_req_t kind;

    always_comb kind = decode_cmd(cmd_i);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_route
        always_comb begin
            req_o[b] = '0;
            if (bank_i == BANK_W'(b)) begin
                req_o[b] = kind;
            end
        end
    end

endmodule

// File: rtl/ap_trk_bank.sv
module ap_trk_bank
    import ap_trk_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int BURST_LEN = 4,
    localparam int WAIT_W   = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  bank_req_t        req_i,
    input  logic [1:0]       cas_lat_i,
    input  logic [CNT_W-1:0] tras_i,
    input  logic [CNT_W-1:0] rd_rec_i,
    input  logic [CNT_W-1:0] wr_rec_i,
    output bank_st_e         st_o,
    output logic             bad_o
);

    bank_st_e          st_q, st_d;
    logic [WAIT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0]  ras_q, ras_d;
    logic [CNT_W-1:0]  rec_q, rec_d;
    logic              act_ok;
    logic              ap_ok;
    logic [WAIT_W-1:0] off;
    logic [WAIT_W-1:0] ras_ext;
    logic [WAIT_W-1:0] wait_cyc;

    always_comb begin
        act_ok   = req_i.act && (st_q == BK_IDLE);
        ap_ok    = (req_i.rda || req_i.wra) && (st_q == BK_OPEN);
        bad_o    = (req_i.act && (st_q != BK_IDLE)) ||
                   ((req_i.rda || req_i.wra || req_i.acc) && (st_q != BK_OPEN));
        off      = WAIT_W'(pchg_offset(req_i.wra, cas_lat_i, BURST_LEN));
        ras_ext  = {1'b0, ras_q};
        wait_cyc = (ras_ext > off) ? ras_ext : off;
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        rec_d = rec_q;
        ras_d = (ras_q == '0) ? '0 : ras_q - 1'b1;
        case (st_q)
            BK_IDLE: begin
                if (act_ok) begin
                    st_d  = BK_OPEN;
                    ras_d = (tras_i == '0) ? '0 : tras_i - 1'b1;
                end
            end
            BK_OPEN: begin
                if (ap_ok) begin
                    st_d  = BK_WAIT;
                    cnt_d = wait_cyc - 1'b1;
                    rec_d = req_i.wra ? wr_rec_i : rd_rec_i;
                end
            end
            BK_WAIT: begin
                if (cnt_q <= WAIT_W'(1)) begin
                    if (rec_q == '0) begin
                        st_d = BK_IDLE;
                    end else begin
                        st_d  = BK_RECOV;
                        cnt_d = {1'b0, rec_q};
                    end
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            BK_RECOV: begin
                if (cnt_q <= WAIT_W'(1)) begin
                    st_d = BK_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: st_d = BK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= BK_IDLE;
            cnt_q <= '0;
            ras_q <= '0;
            rec_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            ras_q <= ras_d;
            rec_q <= rec_d;
        end
    end

    assign st_o = st_q;

endmodule

// File: rtl/ap_trk_viol.sv
module ap_trk_viol #(
    parameter int NUM_BANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_BANKS-1:0] bad_i,
    output logic                 viol_o
);

    logic viol_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            viol_q <= 1'b0;
        end else begin
            viol_q <= |bad_i;
        end
    end

    assign viol_o = viol_q;

endmodule

// File: rtl/ap_bank_tracker.sv
module ap_bank_tracker
    import ap_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int CNT_W     = 4,
    parameter int BURST_LEN = 4,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2:0]           cmd_i,
    input  logic [BANK_W-1:0]    bank_i,
    input  logic [1:0]           cas_lat_i,
    input  logic [CNT_W-1:0]     tras_i,
    input  logic [CNT_W-1:0]     rd_rec_i,
    input  logic [CNT_W-1:0]     wr_rec_i,
    output logic [NUM_BANKS-1:0] bank_ready_o,
    output logic [NUM_BANKS-1:0] bank_idle_o,
    output logic [NUM_BANKS-1:0] bank_pchg_o,
    output logic                 viol_o
);

    bank_req_t              req [NUM_BANKS];
    bank_st_e               st  [NUM_BANKS];
    logic [NUM_BANKS-1:0]   bad;

    ap_trk_cmd_dec #(
        .NUM_BANKS (NUM_BANKS)
    ) u_dec (
        .cmd_i  (cmd_i),
        .bank_i (bank_i),
        .req_o  (req)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ap_trk_bank #(
            .CNT_W     (CNT_W),
            .BURST_LEN (BURST_LEN)
        ) u_bank (
            .clk       (clk),
            .rst       (rst),
            .req_i     (req[b]),
            .cas_lat_i (cas_lat_i),
            .tras_i    (tras_i),
            .rd_rec_i  (rd_rec_i),
            .wr_rec_i  (wr_rec_i),
            .st_o      (st[b]),
            .bad_o     (bad[b])
        );

        assign bank_ready_o[b] = (st[b] == BK_IDLE) || (st[b] == BK_OPEN);
        assign bank_idle_o[b]  = (st[b] == BK_IDLE);
        assign bank_pchg_o[b]  = (st[b] == BK_RECOV);
    end

    ap_trk_viol #(
        .NUM_BANKS (NUM_BANKS)
    ) u_viol (
        .clk    (clk),
        .rst    (rst),
        .bad_i  (bad),
        .viol_o (viol_o)
    );

endmodule

// File: rtl/ap_trk_chk.sv
module ap_trk_chk #(
    parameter int NUM_BANKS = 4,
    parameter int CNT_W     = 4,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic [2:0]           cmd_i,
    input logic [BANK_W-1:0]    bank_i,
    input logic [1:0]           cas_lat_i,
    input logic [CNT_W-1:0]     tras_i,
    input logic [CNT_W-1:0]     rd_rec_i,
    input logic [CNT_W-1:0]     wr_rec_i,
    input logic [NUM_BANKS-1:0] bank_ready_o,
    input logic [NUM_BANKS-1:0] bank_idle_o,
    input logic [NUM_BANKS-1:0] bank_pchg_o,
    input logic                 viol_o
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> ((&bank_idle_o) && !viol_o && (bank_pchg_o == '0))); // R1

    AST_NOP_NO_VIOL: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == 3'd0) |=> !viol_o); // R8

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
        AST_ACT_OPENS: assert property (@(posedge clk) disable iff (rst)
            (cmd_i == 3'd1 && bank_i == BANK_W'(b) && bank_idle_o[b])
            |=> (!bank_idle_o[b] && bank_ready_o[b] && !bank_pchg_o[b])); // R2

        AST_ACT_BUSY_FLAGS: assert property (@(posedge clk) disable iff (rst)
            (cmd_i == 3'd1 && bank_i == BANK_W'(b) && !bank_idle_o[b])
            |=> viol_o); // R8

        AST_AP_BLOCKS: assert property (@(posedge clk) disable iff (rst)
            ((cmd_i == 3'd2 || cmd_i == 3'd3) && bank_i == BANK_W'(b) &&
             bank_ready_o[b] && !bank_idle_o[b])
            |=> (!bank_ready_o[b] && !bank_pchg_o[b])); // R3

        AST_PCHG_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
            bank_pchg_o[b] |-> (!bank_ready_o[b] && !bank_idle_o[b])); // R6

        AST_PCHG_ENDS_IDLE: assert property (@(posedge clk) disable iff (rst)
            $fell(bank_pchg_o[b]) |-> bank_idle_o[b]); // R7
    end

endmodule

bind ap_bank_tracker ap_trk_chk #(
    .NUM_BANKS (NUM_BANKS),
    .CNT_W     (CNT_W)
) u_chk (.*);

// File: tb/ap_bank_tracker_tb.sv
`timescale 1ns/100ps
module ap_bank_tracker_tb;

    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    cmd_i = '0;
    logic [1:0]    bank_i = '0;
    logic [1:0]    cas_lat_i = 2'd3;
    logic [3:0]    tras_i = '0;
    logic [3:0]    rd_rec_i = '0;
    logic [3:0]    wr_rec_i = '0;
    logic [NB-1:0] bank_ready_o;
    logic [NB-1:0] bank_idle_o;
    logic [NB-1:0] bank_pchg_o;
    logic          viol_o;

    always #2.5 clk = ~clk;

    ap_bank_tracker u_dut (
        .clk          (clk),
        .rst          (rst),
        .cmd_i        (cmd_i),
        .bank_i       (bank_i),
        .cas_lat_i    (cas_lat_i),
        .tras_i       (tras_i),
        .rd_rec_i     (rd_rec_i),
        .wr_rec_i     (wr_rec_i),
        .bank_ready_o (bank_ready_o),
        .bank_idle_o  (bank_idle_o),
        .bank_pchg_o  (bank_pchg_o),
        .viol_o       (viol_o)
    );

    // Timestamp model: 0 idle, 1 open, 2 auto-precharge scheduled
    int    mode    [NB];
    int    ras_end [NB];
    int    p_t     [NB];
    int    r_t     [NB];
    bit    is_wr   [NB];
    bit    by_ras  [NB];
    int    cyc;
    bit    exp_viol;
    int    checks;
    int    errors;
    bit    done;
    string tag_force;

    function automatic int st_of(int b);
        if (mode[b] == 0) return 0;
        if (mode[b] == 1) return 1;
        if (cyc < p_t[b]) return 2;
        if (cyc < r_t[b]) return 3;
        return 0;
    endfunction

    function automatic string tag_of(int b);
        int s;
        s = st_of(b);
        if (tag_force != "") return tag_force;
        if (s <= 1) return "R2";
        if (s == 2) return by_ras[b] ? "R5" : (is_wr[b] ? "R4" : "R3");
        return is_wr[b] ? "R7" : "R6";
    endfunction

    task automatic chk(string tag, string what, int b, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s bank %0d cycle %0d: got %0d expected %0d",
                     tag, what, b, cyc, act, exp);
        end
    endtask

    task automatic check_all();
        for (int b = 0; b < NB; b++) begin
            int s;
            s = st_of(b);
            chk(tag_of(b), "ready", b, int'(bank_ready_o[b]), int'(s <= 1));
            chk(tag_of(b), "idle",  b, int'(bank_idle_o[b]),  int'(s == 0));
            chk(tag_of(b), "pchg",  b, int'(bank_pchg_o[b]),  int'(s == 3));
        end
        chk((tag_force != "") ? tag_force : "R8", "viol", -1,
            int'(viol_o), int'(exp_viol));
    endtask

    task automatic step(int c, int b, int cl, int tr, int la, int ld);
        int s;
        int base;
        bit bad;
        check_all();
        s   = st_of(b);
        bad = 1'b0;
        if (c == 1) begin
            if (s == 0) begin
                mode[b]    = 1;
                ras_end[b] = cyc + tr;
            end else bad = 1'b1;
        end else if (c == 2 || c == 3) begin
            if (s == 1) begin
                mode[b]  = 2;
                is_wr[b] = (c == 3);
                if (c == 3) base = cyc + 3;
                else        base = cyc + cl + 3 - ((cl == 3) ? 2 : 1);
                by_ras[b] = (ras_end[b] > base);
                p_t[b]    = by_ras[b] ? ras_end[b] : base;
                r_t[b]    = p_t[b] + ((c == 3) ? ld : la);
            end else bad = 1'b1;
        end else if (c != 0) begin
            if (s != 1) bad = 1'b1;
        end
        cmd_i     = 3'(c);
        bank_i    = 2'(b);
        cas_lat_i = 2'(cl);
        tras_i    = 4'(tr);
        rd_rec_i  = 4'(la);
        wr_rec_i  = 4'(ld);
        @(posedge clk);
        cyc++;
        exp_viol = bad;
        @(negedge clk);
    endtask

    task automatic nops(int n);
        for (int i = 0; i < n; i++) step(0, 0, 3, 0, 0, 0);
    endtask

    task automatic do_reset();
        rst   = 1'b1;
        cmd_i = '0;
        repeat (2) @(posedge clk);
        for (int b = 0; b < NB; b++) mode[b] = 0;
        exp_viol = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        cyc = 0;
        tag_force = "R1";
        check_all();
        tag_force = "";
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        checks = 0;
        errors = 0;
        done   = 1'b0;
        cyc    = 0;
        tag_force = "";
        void'($urandom(32'h5eed_0a17));
        for (int b = 0; b < NB; b++) begin
            mode[b] = 0; ras_end[b] = 0; p_t[b] = 0; r_t[b] = 0;
            is_wr[b] = 0; by_ras[b] = 0;
        end
        @(negedge clk);
        do_reset();                                   // R1

        // R3 / R6: CL3 read, recovery 3
        step(1, 0, 3, 0, 0, 0);
        step(0, 0, 3, 0, 0, 0);
        step(2, 0, 3, 0, 3, 0);
        nops(9);
        // R3 / R6: CL2 read, zero recovery
        step(1, 1, 2, 0, 0, 0);
        step(2, 1, 2, 0, 0, 0);
        nops(7);
        // R5: row-active limit later than latency point
        step(1, 2, 3, 12, 0, 0);
        step(2, 2, 3, 0, 2, 0);
        nops(16);
        // R4 / R7: write, then write bounded by tRAS
        step(1, 3, 3, 0, 0, 0);
        step(3, 3, 3, 0, 0, 4);
        nops(9);
        step(1, 3, 2, 9, 0, 0);
        step(3, 3, 2, 0, 0, 2);
        nops(12);

        // R8: illegal commands are flagged and ignored
        tag_force = "R8";
        step(1, 0, 3, 0, 0, 0);
        step(1, 0, 3, 15, 0, 0);
        step(2, 0, 3, 0, 1, 0);
        step(2, 0, 3, 0, 9, 0);
        step(5, 0, 3, 0, 0, 0);
        step(1, 0, 3, 0, 0, 0);
        nops(6);
        step(4, 0, 3, 0, 0, 0);
        step(3, 0, 3, 0, 0, 0);
        nops(2);

        // R9: interleaved banks keep separate timing
        tag_force = "R9";
        step(1, 0, 3, 6, 0, 0);
        step(1, 1, 3, 0, 0, 0);
        step(2, 0, 3, 0, 2, 0);
        step(3, 1, 3, 0, 0, 6);
        step(1, 2, 3, 0, 0, 0);
        step(2, 2, 2, 0, 5, 0);
        step(1, 3, 3, 0, 0, 0);
        nops(14);

        // R10: timing inputs change after sampling
        tag_force = "R10";
        step(1, 1, 3, 10, 0, 0);
        step(0, 1, 3, 0, 15, 15);
        step(2, 1, 3, 1, 5, 0);
        step(0, 1, 3, 15, 0, 15);
        nops(16);
        tag_force = "";

        // Constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            int b, r, s, cl;
            b  = int'($urandom % NB);
            r  = int'($urandom % 10);
            cl = ($urandom % 2 == 0) ? 2 : 3;
            s  = st_of(b);
            if (r < 4) begin
                step(0, b, cl, int'($urandom % 16), int'($urandom % 16),
                     int'($urandom % 16));
            end else if (r < 9) begin
                int c;
                if (s == 0)      c = 1;
                else if (s == 1) c = ($urandom % 3 == 0) ? 4 : 2 + int'($urandom % 2);
                else             c = 0;
                step(c, b, cl, int'($urandom % 16), int'($urandom % 8),
                     int'($urandom % 8));
            end else begin
                step(1 + int'($urandom % 7), b, cl, int'($urandom % 16),
                     int'($urandom % 16), int'($urandom % 16));
            end
            if (i == 2000) do_reset();                // R1 mid-run
        end
        nops(40);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule